// File: doc/BRIEF.md
# Trigger Input Conditioning and Majority

The block turns seven front-panel trigger inputs into one trigger decision. Each input may be inverted and then masked by its own enable. A per-input pulse-width shaper then stretches every leading edge into a pulse of programmable length. The shaped lines are counted, and the count is compared against two majority thresholds, a low one and a high one.

The two comparison results, an "any input active" flag and an external trigger line together form a 4-bit logic state. That state selects one bit of a 16-bit programmable lookup word. A rising edge of the selected bit produces a single-clock trigger pulse. The logic state is also brought out so that later counting logic can use it.

Configuration arrives as plain level inputs that are held by a register block outside this one. The package supplies the reset-time threshold values that such a register block should use: low = 1 and high = 7.

The shaper of each input is a two-state machine. In SH_IDLE, a leading edge moves it to SH_HOLD and loads the counter. In SH_HOLD, a leading edge reloads the counter, and the counter reaching zero returns the machine to SH_IDLE. The trigger pulse generator is a three-state machine. In PG_IDLE, a high decision moves it to PG_FIRE. In PG_FIRE, which drives the pulse, a high decision moves it to PG_HELD and a low one returns it to PG_IDLE. In PG_HELD, a low decision returns it to PG_IDLE.

Top module: `trig_conditioner`

## Requirements
- R1: While `rst_n` is low and directly after it rises, `trig_out` is 0 and `logic_state` is 0.
- R2: The condition of input i is `nim_in[i] XOR in_invert[i]`. An inverted input that is held high counts as inactive, and its falling level is a leading edge.
- R3: An input whose `in_enable` bit is 0 counts as inactive, whatever its level or its inversion bit.
- R4: A leading edge is a condition that is 0 at one clock sample and 1 at the next. It makes the shaped line active for exactly `shaper_width`+1 clocks, and holding the condition high does not lengthen the pulse.
- R5: A new leading edge while the shaped pulse is active restarts the full width from that edge.
- R6: `logic_state` is registered one clock after the shaped lines. Bit 0 is set when any shaped line is active. Bit 1 is set when the count of active lines is at least `maj_low`. Bit 2 is set when that count is at least `maj_high`. Bit 3 is `ext_trig` as sampled at that clock.
- R7: The trigger decision is bit `logic_state` of `lut_word`, where the index is the state value 0..15. State 0 never gives a decision, whatever `lut_word[0]` holds.
- R8: `trig_out` goes high for exactly one clock, in the clock after the decision rises. A decision that stays high gives no further pulse until it has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per shaper step |
| rst_n | input | 1 | Asynchronous active-low reset |
| nim_in | input | 7 | Raw trigger inputs |
| ext_trig | input | 1 | External trigger level, state bit 3 |
| in_enable | input | 7 | Per-input enable |
| in_invert | input | 7 | Per-input inversion |
| shaper_width | input | 8 | Shaped pulse length minus one, in clocks |
| maj_low | input | 3 | Low majority threshold |
| maj_high | input | 3 | High majority threshold |
| lut_word | input | 16 | Decision bit per logic state |
| trig_out | output | 1 | Single-clock trigger pulse |
| logic_state | output | 4 | Registered logic state |

## Verification
An input condition that is sampled at clock edge k reaches the shaper output at edge k. It appears in `logic_state` at edge k+1 and in `trig_out` at edge k+2. `ext_trig` skips the shaper, so its effects arrive at k and k+1. The bench keeps a behavioural model that applies these delays with integer countdowns and a one-entry history of the decision. It drives inputs on the falling edge and compares `logic_state` and `trig_out` with the model on every falling edge. Directed windows count the shaped and trigger cycles so that each expected count can be compared in full.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
    localparam int NIM_COUNT        = 7;
    localparam int SHAPE_BITS       = 8;
    localparam int THRESH_BITS      = 3;
    localparam int STATE_BITS       = 4;
    localparam int MAJ_LOW_DEFAULT  = 1;
    localparam int MAJ_HIGH_DEFAULT = 7;

    typedef enum logic [0:0] {
        SH_IDLE,
        SH_HOLD
    } shaper_state_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_FIRE,
        PG_HELD
    } pulse_state_e;

    typedef struct packed {
        logic ext;
        logic high;
        logic low;
        logic any;
    } logic_state_t;
endpackage

// File: rtl/trig_shaper.sv
module trig_shaper
    import trig_cond_pkg::*;
#(
    parameter int WIDTH_BITS = SHAPE_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cond,
    input  logic [WIDTH_BITS-1:0] width,
    output logic                  active
);
    shaper_state_e         state_q, state_d;
    logic [WIDTH_BITS-1:0] left_q, left_d;
    logic                  cond_q;
    logic                  lead;

    assign lead = cond & ~cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            left_q  <= '0;
            cond_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            cond_q  <= cond;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            SH_IDLE: begin
                if (lead) begin
                    state_d = SH_HOLD;
                    left_d  = width;
                end
            end
            SH_HOLD: begin
                if (lead) begin
                    left_d = width;
                end else if (left_q == '0) begin
                    state_d = SH_IDLE;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: state_d = SH_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == SH_HOLD);
    end
endmodule

// File: rtl/trig_majority.sv
module trig_majority
    import trig_cond_pkg::*;
#(
    parameter int N_IN = NIM_COUNT,
    parameter int TH_W = THRESH_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  shaped,
    input  logic             ext_trig,
    input  logic [TH_W-1:0]  maj_low,
    input  logic [TH_W-1:0]  maj_high,
    output logic_state_t     state_q
);
    localparam int CNT_W = $clog2(N_IN + 1);

    logic [CNT_W-1:0] ones;
    logic_state_t     state_d;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N_IN; i++) begin
            ones = ones + CNT_W'(shaped[i]);
        end
    end

    always_comb begin
        state_d.ext  = ext_trig;
        state_d.high = int'(ones) >= int'(maj_high);
        state_d.low  = int'(ones) >= int'(maj_low);
        state_d.any  = (ones != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import trig_cond_pkg::*;
#(
    parameter int ST_W = STATE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ST_W-1:0]      state_in,
    input  logic [(1<<ST_W)-1:0] lut,
    output logic                 trig
);
    pulse_state_e pg_q, pg_d;
    logic         decision;

    assign decision = (state_in != '0) && lut[state_in];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= PG_IDLE;
        end else begin
            pg_q <= pg_d;
        end
    end

    always_comb begin
        pg_d = pg_q;
        unique case (pg_q)
            PG_IDLE: if (decision)  pg_d = PG_FIRE;
            PG_FIRE: pg_d = decision ? PG_HELD : PG_IDLE;
            PG_HELD: if (!decision) pg_d = PG_IDLE;
            default: pg_d = PG_IDLE;
        endcase
    end

    always_comb begin
        trig = (pg_q == PG_FIRE);
    end
endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
    import trig_cond_pkg::*;
#(
    parameter int N_IN = NIM_COUNT,
    parameter int SH_W = SHAPE_BITS,
    parameter int TH_W = THRESH_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        nim_in,
    input  logic                   ext_trig,
    input  logic [N_IN-1:0]        in_enable,
    input  logic [N_IN-1:0]        in_invert,
    input  logic [SH_W-1:0]        shaper_width,
    input  logic [TH_W-1:0]        maj_low,
    input  logic [TH_W-1:0]        maj_high,
    input  logic [(1<<STATE_BITS)-1:0] lut_word,
    output logic                   trig_out,
    output logic [STATE_BITS-1:0]  logic_state
);
    logic [N_IN-1:0] cond;
    logic [N_IN-1:0] shaped;
    logic_state_t    st;

    for (genvar g = 0; g < N_IN; g++) begin : g_chan
        assign cond[g] = (nim_in[g] ^ in_invert[g]) & in_enable[g];

        trig_shaper #(.WIDTH_BITS(SH_W)) i_shaper (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (cond[g]),
            .width  (shaper_width),
            .active (shaped[g])
        );
    end

    trig_majority #(.N_IN(N_IN), .TH_W(TH_W)) i_majority (
        .clk      (clk),
        .rst_n    (rst_n),
        .shaped   (shaped),
        .ext_trig (ext_trig),
        .maj_low  (maj_low),
        .maj_high (maj_high),
        .state_q  (st)
    );

    assign logic_state = st;

    trig_pulse_gen #(.ST_W(STATE_BITS)) i_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_in (logic_state),
        .lut      (lut_word),
        .trig     (trig_out)
    );
endmodule

// File: rtl/trig_conditioner_chk.sv
module trig_conditioner_chk
    import trig_cond_pkg::*;
#(
    parameter int N_IN = NIM_COUNT
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ext_trig,
    input logic [N_IN-1:0]             in_enable,
    input logic [N_IN-1:0]             shaped,
    input logic [(1<<STATE_BITS)-1:0]  lut_word,
    input logic                        trig_out,
    input logic [STATE_BITS-1:0]       logic_state
);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R7
    lut_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(lut_word[logic_state]));

    // R7
    zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ($past(logic_state) != '0));

    // R6
    ext_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (logic_state[3] == $past(ext_trig)));

    // R6
    any_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (logic_state[0] == ($past(shaped) != '0)));

    for (genvar g = 0; g < N_IN; g++) begin : g_en
        // R3
        masked_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(shaped[g]) |-> $past(in_enable[g]));
    end
endmodule

bind trig_conditioner trig_conditioner_chk #(.N_IN(N_IN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_trig    (ext_trig),
    .in_enable   (in_enable),
    .shaped      (shaped),
    .lut_word    (lut_word),
    .trig_out    (trig_out),
    .logic_state (logic_state)
);

// File: tb/test_trig_conditioner.sv
module test_trig_conditioner;
    import trig_cond_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = NIM_COUNT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      nim_in = '0;
    logic              ext_trig = 1'b0;
    logic [N-1:0]      in_enable = '0;
    logic [N-1:0]      in_invert = '0;
    logic [7:0]        shaper_width = '0;
    logic [2:0]        maj_low = 3'(MAJ_LOW_DEFAULT);
    logic [2:0]        maj_high = 3'(MAJ_HIGH_DEFAULT);
    logic [15:0]       lut_word = '0;
    logic              trig_out;
    logic [3:0]        logic_state;

    int total = 0;
    int bad = 0;
    int n_any = 0;
    int n_trig = 0;
    bit done = 0;

    // reference model state
    int       m_rem [N];
    bit       m_prev [N];
    bit [3:0] m_state;
    bit       m_trig;
    bit       m_hit_prev;

    trig_conditioner i_trig_conditioner (
        .clk          (clk),
        .rst_n        (rst_n),
        .nim_in       (nim_in),
        .ext_trig     (ext_trig),
        .in_enable    (in_enable),
        .in_invert    (in_invert),
        .shaper_width (shaper_width),
        .maj_low      (maj_low),
        .maj_high     (maj_high),
        .lut_word     (lut_word),
        .trig_out     (trig_out),
        .logic_state  (logic_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int       act;
        bit       c;
        bit       hit;
        bit [3:0] ns;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_rem[i] = 0;
                m_prev[i] = 0;
            end
            m_state = '0;
            m_trig = 0;
            m_hit_prev = 0;
        end else begin
            act = 0;
            for (int i = 0; i < N; i++) if (m_rem[i] > 0) act++;
            ns = {ext_trig, act >= int'(maj_high), act >= int'(maj_low), act > 0};
            hit = (m_state != 0) && lut_word[m_state];
            m_trig = hit && !m_hit_prev;
            m_hit_prev = hit;
            m_state = ns;
            for (int i = 0; i < N; i++) begin
                c = (nim_in[i] ^ in_invert[i]) & in_enable[i];
                if (c && !m_prev[i]) m_rem[i] = int'(shaper_width) + 1;
                else if (m_rem[i] > 0) m_rem[i]--;
                m_prev[i] = c;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(logic_state == m_state, "R6 state vs model", int'(logic_state), int'(m_state));
            chk(trig_out == m_trig, "R8 trigger vs model", int'(trig_out), int'(m_trig));
            if (logic_state[0]) n_any++;
            if (trig_out) n_trig++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_any = 0;
        n_trig = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            chk(0, "watchdog R8", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk(trig_out == 0 && logic_state == 0, "R1 in reset", int'(logic_state), 0);
        rst_n = 1'b1;
        cyc(1);
        chk(trig_out == 0 && logic_state == 0, "R1 after release", int'(logic_state), 0);

        // R4: width field+1, held input does not extend
        in_enable = 7'b0000001;
        shaper_width = 8'd4;
        clear_counts();
        nim_in[0] = 1'b1;
        cyc(20);
        nim_in[0] = 1'b0;
        cyc(6);
        chk(n_any == 5, "R4 shaped width", n_any, 5);

        // R5: retrigger restarts full width
        shaper_width = 8'd9;
        clear_counts();
        nim_in[0] = 1'b1;
        cyc(3);
        nim_in[0] = 1'b0;
        cyc(2);
        nim_in[0] = 1'b1;
        cyc(20);
        nim_in[0] = 1'b0;
        cyc(6);
        chk(n_any == 15, "R5 retriggered width", n_any, 15);

        // R3: disabled input ignored, even when inverted
        shaper_width = 8'd2;
        in_enable = 7'b1111101;
        in_invert = 7'b0000010;
        clear_counts();
        for (int k = 0; k < 10; k++) begin
            nim_in[1] = ~nim_in[1];
            cyc(2);
        end
        nim_in[1] = 1'b0;
        cyc(4);
        chk(n_any == 0, "R3 disabled input", n_any, 0);
        in_invert = '0;

        // R2: inverted input held high is inactive; falling level is an edge
        clear_counts();
        nim_in[2] = 1'b1;
        in_invert[2] = 1'b1;
        cyc(10);
        chk(n_any == 0, "R2 inverted high idle", n_any, 0);
        nim_in[2] = 1'b0;
        cyc(10);
        chk(n_any == 3, "R2 inverted falling edge", n_any, 3);
        nim_in[2] = 1'b0;
        in_invert[2] = 1'b0;
        cyc(4);

        // R6: majority bits and ext bit
        in_enable = '1;
        shaper_width = 8'd7;
        maj_low = 3'd2;
        maj_high = 3'd3;
        nim_in = 7'b0000011;
        cyc(1);
        nim_in = '0;
        cyc(1);
        chk(logic_state == 4'd3, "R6 two inputs", int'(logic_state), 3);
        cyc(12);
        nim_in = 7'b0010101;
        cyc(1);
        nim_in = '0;
        cyc(1);
        chk(logic_state == 4'd7, "R6 three inputs", int'(logic_state), 7);
        cyc(12);
        ext_trig = 1'b1;
        cyc(1);
        chk(logic_state == 4'd8, "R6 ext only", int'(logic_state), 8);
        ext_trig = 1'b0;
        cyc(3);

        // R7: state 0 never triggers; selected bit decides
        lut_word = 16'h0001;
        clear_counts();
        cyc(10);
        chk(n_trig == 0, "R7 state zero", n_trig, 0);
        lut_word = 16'h0008;
        nim_in = 7'b0000011;
        cyc(1);
        nim_in = '0;
        cyc(12);
        chk(n_trig == 1, "R7 state 3 selected", n_trig, 1);
        clear_counts();
        nim_in = 7'b0000111;
        cyc(1);
        nim_in = '0;
        cyc(12);
        chk(n_trig == 0, "R7 state 7 not selected", n_trig, 0);

        // R8: one pulse per rising decision, latency one clock after state
        lut_word = 16'h0100;
        clear_counts();
        ext_trig = 1'b1;
        cyc(2);
        chk(trig_out == 1'b1, "R8 pulse timing", int'(trig_out), 1);
        cyc(1);
        chk(trig_out == 1'b0, "R8 pulse one clock", int'(trig_out), 0);
        cyc(8);
        ext_trig = 1'b0;
        cyc(2);
        chk(n_trig == 1, "R8 held decision", n_trig, 1);
        ext_trig = 1'b1;
        cyc(4);
        ext_trig = 1'b0;
        cyc(2);
        chk(n_trig == 2, "R8 re-armed after low", n_trig, 2);

        // mixed stimulus against the model
        for (int k = 0; k < 3000; k++) begin
            nim_in = N'($urandom) & N'($urandom) & N'($urandom);
            ext_trig = ($urandom % 8) == 0;
            if (k % 200 == 0) begin
                in_enable = N'($urandom) | N'(7'b0001111);
                in_invert = N'($urandom) & N'($urandom);
                shaper_width = 8'($urandom % 6);
                maj_low = 3'($urandom);
                maj_high = 3'($urandom);
                lut_word = 16'($urandom);
            end
            cyc(1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule